// File: doc/BRIEF.md
# Prescaled Dual-Channel PWM Controller

This block generates up to two pulse width modulated outputs from a single register-mapped configuration. Every channel owns a field in one shared control word and a separate period/duty word. The control field chooses a clock divider from a fixed set of uneven ratios, or no division at all. It also holds an enable bit, a clock gate bit and the polarity of the active level. The period/duty word sets how many divided ticks one output cycle lasts and for how many of those ticks the output is active.

Writes to a period/duty word first land in a shadow copy. A running channel takes the new values only when its current output cycle completes, so the waveform never shows a truncated or merged cycle. A per-channel ready flag in the control word reads 0 while such a load is waiting. A stopped channel takes the new values on the next clock.

The register port is a plain single-cycle write strobe with a byte address and a combinational read data path. Only word-aligned addresses decode.

Top module: `dual_pwm_unit`

## Requirements
- R1: The control word sits at byte address 0x0 and channel n's period/duty word at 0x4 + 4*n. Channel n's control field starts at bit 15*n: divider code in [3:0], enable at bit 4, active-level select at bit 5, clock gate at bit 6. All other control bits are not stored and read 0, except the ready flags. Period/duty words read back the last value written.
- R2: After reset the control word reads 0x3000_0000 (only the ready flags set), both period/duty words read 0, and every output is high.
- R3: A channel runs only when its gate bit, its enable bit and a valid divider code are all present. Otherwise its counters hold and its output sits at the inactive level, which is the inverse of the active-level select bit.
- R4: Divider codes 0..4 divide the clock by 120, 180, 240, 360 and 480. Codes 8..12 divide it by 12000, 24000, 36000, 48000 and 72000. Code 15 divides by 1 when the bypass parameter is set. Codes 5..7, 13 and 14 are invalid, and so is code 15 without bypass.
- R5: In a period/duty word, bits [31:16] hold the cycle length in ticks minus one and bits [15:0] hold the number of active ticks at the start of each cycle.
- R6: With active-level select 1 the active portion drives the output high. With select 0 it drives the output low.
- R7: A duty value not smaller than the cycle length keeps the output active for the whole cycle. A duty value of 0 keeps it inactive.
- R8: A period/duty write on a running channel takes effect at the end of the current cycle; on a stopped channel it takes effect on the next clock. Ready flag n, at control bit 28 + n, reads 0 while the load is pending and ignores writes.
- R9: Writing a new divider code while the channel's gate bit is 0 clears its divider count, so the first tick after the gate is set again takes a full divider period.
- R10: Outputs are registered and lag the cycle counter by one clock. Each channel runs independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | NUM_CH | PWM outputs |

## Verification
A register write lands at the clock edge that samples it, so read-back checks read at the following falling edge. A ready flag that drops is therefore seen low at once, and the bench then polls it against a bound of one full cycle. Waveform results are measured by a monitor that counts active and total cycles between active-going edges. Those counts do not depend on the one-clock output register. The divider-clear case is an exception: it counts the first active stretch after the gate turns on, which must be exactly one divided tick (180 clocks). Constant-level checks wait one full output cycle after the write, so that the shadow load has happened, before they sample.

// File: rtl/pwm_unit_pkg.sv
package pwm_unit_pkg;
  localparam int DATA_W       = 32;
  localparam int CODE_W       = 4;
  localparam int DIV_W        = 17;
  localparam int CNT_W        = 16;
  localparam int FIELD_STRIDE = 15;
  localparam int READY_BASE   = 28;

  // Per-channel control field; packed order gives bit 6 = gate ... bits 3:0 = code.
  typedef struct packed {
    logic              gate;
    logic              act_hi;
    logic              en;
    logic [CODE_W-1:0] code;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);

  typedef struct packed {
    logic             ok;
    logic [DIV_W-1:0] ratio;
  } div_sel_t;

  function automatic div_sel_t div_lookup(input logic [CODE_W-1:0] code, input bit bypass);
    div_sel_t s;
    s.ok    = 1'b1;
    s.ratio = '0;
    case (code)
      4'd0:  s.ratio = DIV_W'(120);
      4'd1:  s.ratio = DIV_W'(180);
      4'd2:  s.ratio = DIV_W'(240);
      4'd3:  s.ratio = DIV_W'(360);
      4'd4:  s.ratio = DIV_W'(480);
      4'd8:  s.ratio = DIV_W'(12000);
      4'd9:  s.ratio = DIV_W'(24000);
      4'd10: s.ratio = DIV_W'(36000);
      4'd11: s.ratio = DIV_W'(48000);
      4'd12: s.ratio = DIV_W'(72000);
      4'd15: begin
        s.ratio = DIV_W'(1);
        s.ok    = bypass;
      end
      default: s.ok = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_unit_pkg::*;
#(
  parameter bit BYPASS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick,
  output logic              valid
);
  div_sel_t         sel;
  logic [DIV_W-1:0] pre_q, pre_n;
  logic             last;
  logic             pre_en;

  always_comb begin
    sel    = div_lookup(code, BYPASS);
    valid  = sel.ok;
    last   = sel.ok && (pre_q >= (sel.ratio - DIV_W'(1)));
    tick   = run && last;
    pre_en = clr || run;
    if (clr)       pre_n = '0;
    else if (last) pre_n = '0;
    else           pre_n = pre_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_n;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              act_hi,
  input  logic              shd_we,
  input  logic [DATA_W-1:0] shd_wdata,
  output logic [DATA_W-1:0] shd_q,
  output logic              ready,
  output logic              pwm_o
);
  logic [CNT_W-1:0] shd_prd_q, shd_dty_q;
  logic [CNT_W-1:0] act_prd_q, act_dty_q;
  logic [CNT_W-1:0] cyc_q, cyc_n;
  logic             pend_q, pend_n;
  logic             out_q, out_n;
  logic             cyc_end, ld_run, ld_idle, load, cyc_en, hit;

  always_comb begin
    cyc_end = (cyc_q >= act_prd_q);
    ld_run  = run && tick && cyc_end && pend_q;
    ld_idle = !run && pend_q;
    load    = ld_run || ld_idle;
    cyc_en  = (run && tick) || ld_idle;
    if (ld_idle || cyc_end) cyc_n = '0;
    else                    cyc_n = cyc_q + CNT_W'(1);
    if (shd_we)    pend_n = 1'b1;
    else if (load) pend_n = 1'b0;
    else           pend_n = pend_q;
    hit   = run && (cyc_q < act_dty_q);
    out_n = hit ? act_hi : !act_hi;
    shd_q = {shd_prd_q, shd_dty_q};
    ready = !pend_q;
    pwm_o = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_prd_q <= '0;
      shd_dty_q <= '0;
    end else if (shd_we) begin
      shd_prd_q <= shd_wdata[DATA_W-1:CNT_W];
      shd_dty_q <= shd_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prd_q <= '0;
      act_dty_q <= '0;
    end else if (load) begin
      act_prd_q <= shd_prd_q;
      act_dty_q <= shd_dty_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (cyc_en) cyc_q <= cyc_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      out_q  <= 1'b1;
    end else begin
      pend_q <= pend_n;
      out_q  <= out_n;
    end
  end
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_unit_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  input  logic [NUM_CH-1:0]        ready,
  input  logic [NUM_CH*DATA_W-1:0] shd_flat,
  output ch_cfg_t [NUM_CH-1:0]     cfg_q,
  output logic [NUM_CH-1:0]        pre_clr,
  output logic [NUM_CH-1:0]        per_we,
  output logic [DATA_W-1:0]        per_wdata,
  output logic [DATA_W-1:0]        reg_rdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]    word;
  logic                 aligned, ctrl_we;
  ch_cfg_t [NUM_CH-1:0] cfg_n;

  always_comb begin
    aligned   = (reg_addr[1:0] == 2'b00);
    word      = reg_addr[ADDR_W-1:2];
    ctrl_we   = reg_we && aligned && (word == '0);
    per_wdata = reg_wdata;
    for (int n = 0; n < NUM_CH; n++) begin
      cfg_n[n]   = ch_cfg_t'(reg_wdata[FIELD_STRIDE*n +: CFG_W]);
      per_we[n]  = reg_we && aligned && (word == WORD_W'(n + 1));
      pre_clr[n] = ctrl_we && !cfg_q[n].gate && (cfg_n[n].code != cfg_q[n].code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (ctrl_we) cfg_q <= cfg_n;
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (word == '0) begin
        for (int n = 0; n < NUM_CH; n++) begin
          reg_rdata[FIELD_STRIDE*n +: CFG_W] = cfg_q[n];
          reg_rdata[READY_BASE + n]          = ready[n];
        end
      end else begin
        for (int n = 0; n < NUM_CH; n++) begin
          if (word == WORD_W'(n + 1)) reg_rdata = shd_flat[DATA_W*n +: DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/dual_pwm_unit.sv
module dual_pwm_unit
  import pwm_unit_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter bit HAS_BYPASS = 1'b1,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  ch_cfg_t [NUM_CH-1:0]     cfg_q;
  logic [NUM_CH-1:0]        pre_clr, per_we, ch_ready, ch_valid, ch_run, ch_tick, ch_act;
  logic [NUM_CH*CODE_W-1:0] ch_code;
  logic [NUM_CH*DATA_W-1:0] shd_flat;
  logic [DATA_W-1:0]        per_wdata;

  pwm_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ready     (ch_ready),
    .shd_flat  (shd_flat),
    .cfg_q     (cfg_q),
    .pre_clr   (pre_clr),
    .per_we    (per_we),
    .per_wdata (per_wdata),
    .reg_rdata (reg_rdata)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign ch_code[CODE_W*n +: CODE_W] = cfg_q[n].code;
    assign ch_act[n] = cfg_q[n].act_hi;
    assign ch_run[n] = cfg_q[n].gate && cfg_q[n].en && ch_valid[n];

    pwm_prescaler #(.BYPASS(HAS_BYPASS)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pre_clr[n]),
      .run   (ch_run[n]),
      .code  (cfg_q[n].code),
      .tick  (ch_tick[n]),
      .valid (ch_valid[n])
    );

    pwm_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ch_run[n]),
      .tick      (ch_tick[n]),
      .act_hi    (cfg_q[n].act_hi),
      .shd_we    (per_we[n]),
      .shd_wdata (per_wdata),
      .shd_q     (shd_flat[DATA_W*n +: DATA_W]),
      .ready     (ch_ready[n]),
      .pwm_o     (pwm_out[n])
    );
  end
endmodule

// File: rtl/dual_pwm_unit_checker.sv
module dual_pwm_unit_checker #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [NUM_CH-1:0]   ch_run,
  input logic [NUM_CH-1:0]   ch_tick,
  input logic [NUM_CH-1:0]   ch_ready,
  input logic [NUM_CH-1:0]   ch_act,
  input logic [NUM_CH*4-1:0] ch_code,
  input logic [NUM_CH-1:0]   pwm_out
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    assert_stopped_inactive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[n] |=> (pwm_out[n] == !$past(ch_act[n])));

    assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[n] |-> ch_run[n]);

    assert_bypass_every_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[n] && ch_code[4*n +: 4] == 4'hF) |-> ch_tick[n]);

    assert_ready_drops_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(4*(n + 1))) |=> !ch_ready[n]);
  end
endmodule

bind dual_pwm_unit dual_pwm_unit_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .ch_run   (ch_run),
  .ch_tick  (ch_tick),
  .ch_ready (ch_ready),
  .ch_act   (ch_act),
  .ch_code  (ch_code),
  .pwm_out  (pwm_out)
);

// File: tb/dual_pwm_unit_bench.sv
module dual_pwm_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  logic [31:0] ctrl_img;

  typedef struct {
    int    ch;
    bit    lvl;
    int    hi;
    int    per;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  dual_pwm_unit u_dual_pwm_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic set_ch(input int ch, input logic [3:0] code, input bit en, input bit act, input bit gate);
    ctrl_img[15*ch +: 15] = {8'h00, gate, act, en, code};
    wr(4'h0, ctrl_img);
  endtask

  task automatic hold(input int ch, input bit lvl, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch] != lvl) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic expect_wave(input int ch, input bit lvl, input int hi, input int per, input string tag);
    exp_t e;
    e.ch = ch; e.lvl = lvl; e.hi = hi; e.per = per; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_mon();
    wait (exp_q.size() == 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the next expected waveform and measures it at the outputs.
  initial begin
    exp_t e;
    bit prev, cur;
    int h, p;
    forever begin
      wait (exp_q.size() > 0);
      e = exp_q[0];
      @(negedge clk);
      prev = pwm_out[e.ch];
      cur  = prev;
      while (!(prev != e.lvl && cur == e.lvl)) begin
        prev = cur;
        @(negedge clk);
        cur = pwm_out[e.ch];
      end
      h = 1;
      @(negedge clk);
      while (pwm_out[e.ch] == e.lvl) begin h++; @(negedge clk); end
      p = h + 1;
      @(negedge clk);
      while (pwm_out[e.ch] != e.lvl) begin p++; @(negedge clk); end
      check(h == e.hi, {e.tag, " active width"}, h, e.hi);
      check(p == e.per, {e.tag, " cycle length"}, p, e.per);
      void'(exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int cnt;
    reg_we = 0; reg_addr = 0; reg_wdata = 0; ctrl_img = 0;
    rst_n = 0;
    idle(4);
    rst_n = 1;

    // R2 reset state
    rd(4'h0, d); check(d == 32'h3000_0000, "R2 control after reset", d, 32'h3000_0000);
    rd(4'h4, d); check(d == 0, "R2 ch0 period word", d, 0);
    rd(4'h8, d); check(d == 0, "R2 ch1 period word", d, 0);
    check(pwm_out == 2'b11, "R2 outputs", pwm_out, 2'b11);

    // R1 read-back and field masking
    wr(4'h4, 32'h0009_0003);
    rd(4'h4, d); check(d == 32'h0009_0003, "R1 period read-back", d, 32'h0009_0003);
    ctrl_img[14:0] = {8'h00, 1'b1, 1'b1, 1'b1, 4'hF};
    wr(4'h0, ctrl_img | 32'h3000_7F80);
    rd(4'h0, d); check(d == (ctrl_img | 32'h3000_0000), "R1 control masking", d, ctrl_img | 32'h3000_0000);

    // R5 bypass: 10-tick cycle, 3 active
    expect_wave(0, 1'b1, 3, 10, "R5 bypass 3/10"); wait_mon();
    // R6 active-low
    set_ch(0, 4'hF, 1, 0, 1);
    expect_wave(0, 1'b0, 3, 10, "R6 active low"); wait_mon();
    set_ch(0, 4'hF, 1, 1, 1);

    // R7 duty boundaries
    wr(4'h4, 32'h0009_000C); idle(30);
    hold(0, 1'b1, 40, "R7 duty above length");
    wr(4'h4, 32'h0009_0000); idle(30);
    hold(0, 1'b0, 40, "R7 duty zero");
    wr(4'h4, 32'h0009_0003); idle(30);

    // R4 dividers on ch1
    wr(4'h8, 32'h0001_0001);
    set_ch(1, 4'h0, 1, 1, 1);
    expect_wave(1, 1'b1, 120, 240, "R4 divide 120"); wait_mon();
    expect_wave(0, 1'b1, 3, 10, "R10 ch0 independent"); wait_mon();
    set_ch(1, 4'h3, 1, 1, 1);
    expect_wave(1, 1'b1, 360, 720, "R4 divide 360"); wait_mon();
    set_ch(1, 4'h0, 1, 1, 1);
    idle(800);

    // R8 shadow load on running channel
    wr(4'h8, 32'h0003_0002);
    rd_now(4'h0, d); check(d[29] == 1'b0, "R8 ready low while pending", d[29], 0);
    cnt = 0;
    while (d[29] == 1'b0 && cnt < 2000) begin rd(4'h0, d); cnt++; end
    check(cnt <= 241, "R8 load within one cycle", cnt, 241);
    expect_wave(1, 1'b1, 240, 480, "R8 new values"); wait_mon();

    // R3 run conditions
    set_ch(1, 4'h0, 0, 1, 1); idle(3);
    hold(1, 1'b0, 50, "R3 enable off");
    set_ch(1, 4'h0, 1, 1, 0); idle(3);
    hold(1, 1'b0, 50, "R3 gate off");
    set_ch(1, 4'h5, 1, 1, 1); idle(3);
    hold(1, 1'b0, 50, "R3 invalid code 5");
    set_ch(1, 4'hD, 1, 0, 1); idle(3);
    hold(1, 1'b1, 50, "R3 invalid code 13 active low");

    // R9 divider clear while gated
    set_ch(1, 4'h0, 1, 1, 1);
    wr(4'h8, 32'h0001_0001);
    idle(301);
    set_ch(1, 4'h0, 1, 1, 0);
    set_ch(1, 4'h1, 1, 1, 0);
    wr(4'h8, 32'h0001_0001);
    idle(2);
    expect_wave(1, 1'b1, 180, 360, "R9 full first tick");
    idle(2);
    set_ch(1, 4'h1, 1, 1, 1);
    wait_mon();

    finish_run();
  end
endmodule